// File: doc/BRIEF.md
# Compare-Vector and Branch-Condition Unit

This block evaluates integer compares and conditional branch decisions for a core that keeps no dedicated flag register. A compare takes two operands, an operation size and a destination register number. It produces a ten-bit vector of condition results that the register write port stores into any general register, so every relation between the two operands is available at once.

The branch side tests a value read from a general register in one of two ways. It can look at a single chosen bit and take the branch when that bit is set, or when it is clear. It can also look at the whole register and take the branch when it is zero, or when it is non-zero. A compare and a branch can be presented in the same cycle, and each result appears one cycle after its valid strobe.

Top module: `cmp_branch_unit`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `wrEn`, `brDone` and `brTaken` are 0.
- R2: A cycle with `cmpValid`=1 gives `wrEn`=1 and `wrAddr` equal to that cycle's `cmpDest` one cycle later. A cycle with `cmpValid`=0 gives `wrEn`=0 one cycle later.
- R3: In `wrData`, bit 0 is equal and bit 1 is not-equal, both taken on the operands truncated to the selected width.
- R4: In `wrData`, bit 2 is signed less-than, bit 3 signed less-or-equal, bit 4 signed greater-than and bit 5 signed greater-or-equal. Each compares the truncated operands after sign extension from the top bit of the selected width.
- R5: In `wrData`, bit 6 is unsigned less-than, bit 7 unsigned less-or-equal, bit 8 unsigned greater-than and bit 9 unsigned greater-or-equal. Each compares the truncated operands after zero extension.
- R6: Bits 63 down to 10 of `wrData` are 0 whenever `wrEn` is 1.
- R7: `cmpSize` 0, 1, 2 and 3 select 8, 16, 32 and 64 bits. Operand bits above the selected width have no effect on the result.
- R8: With `brMode` 0 the branch is taken when bit `brBitIdx` of `brSrc` is 0. With `brMode` 1 it is taken when that bit is 1.
- R9: With `brMode` 2 the branch is taken when `brSrc` is all zeros. With `brMode` 3 it is taken when `brSrc` is non-zero. `brBitIdx` has no effect in these modes.
- R10: `brDone` is 1 exactly one cycle after a cycle with `brValid`=1. `brTaken` is 0 whenever `brDone` is 0.
- R11: A compare and a branch presented in the same cycle both complete one cycle later, and neither changes the other's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpValid | input | 1 | Compare request strobe |
| cmpSize | input | 2 | Operation size code: 0=8, 1=16, 2=32, 3=64 bits |
| cmpOpA | input | 64 | First compare operand |
| cmpOpB | input | 64 | Second compare operand |
| cmpDest | input | 6 | Destination general register number |
| brValid | input | 1 | Branch evaluation strobe |
| brMode | input | 2 | 0 bit clear, 1 bit set, 2 register zero, 3 register non-zero |
| brBitIdx | input | 6 | Bit position tested in modes 0 and 1 |
| brSrc | input | 64 | Register value read for the branch |
| wrEn | output | 1 | Register write enable for the condition vector |
| wrAddr | output | 6 | Register write address |
| wrData | output | 64 | Condition vector written to the register |
| brDone | output | 1 | Branch decision valid |
| brTaken | output | 1 | Branch taken when `brDone` is 1 |

## Verification
The bench goes after truncation. It uses operands that differ only above the selected width, so a design that ignored the size would report not-equal where equal is expected. It also uses operands whose top bit within the width is set, so a design that sign-extended from bit 63 would flip the signed and unsigned bits against each other. The bit-test branches are run at positions 0, 63 and in the middle: an off-by-one index or swapped set/clear polarity would change the taken flag. Zero tests are run with a non-zero bit index and with a single set bit at the top, which exposes a design that tests only one bit or only the low half. Back-to-back and simultaneous requests catch a design that holds a stale result or lets one path block the other.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  // Condition vector bit positions (software decodes these).
  localparam int CV_EQ  = 0;
  localparam int CV_NE  = 1;
  localparam int CV_SLT = 2;
  localparam int CV_SLE = 3;
  localparam int CV_SGT = 4;
  localparam int CV_SGE = 5;
  localparam int CV_ULT = 6;
  localparam int CV_ULE = 7;
  localparam int CV_UGT = 8;
  localparam int CV_UGE = 9;
  localparam int CV_N   = 10;

  typedef enum logic [1:0] {
    BR_BIT_CLR  = 2'd0,
    BR_BIT_SET  = 2'd1,
    BR_ZERO     = 2'd2,
    BR_NONZERO  = 2'd3
  } brMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic cmpLoad;
    logic brLoad;
    logic brWholeReg;
    logic brWantSet;
  } ctrlStrobe_t;

endpackage

// File: rtl/cbu_ctrl.sv
module cbu_ctrl
  import cbu_pkg::*;
(
  input  logic        cmpValid,
  input  logic        brValid,
  input  logic [1:0]  brMode,
  output ctrlStrobe_t strobe
);

  brMode_e modeSel;

  always_comb begin
    modeSel = brMode_e'(brMode);
    strobe = '0;
    strobe.cmpLoad = cmpValid;
    strobe.brLoad  = brValid;
    unique case (modeSel)
      BR_BIT_CLR: begin strobe.brWholeReg = 1'b0; strobe.brWantSet = 1'b0; end
      BR_BIT_SET: begin strobe.brWholeReg = 1'b0; strobe.brWantSet = 1'b1; end
      BR_ZERO:    begin strobe.brWholeReg = 1'b1; strobe.brWantSet = 1'b0; end
      BR_NONZERO: begin strobe.brWholeReg = 1'b1; strobe.brWantSet = 1'b1; end
      default:    begin strobe.brWholeReg = 1'b0; strobe.brWantSet = 1'b0; end
    endcase
  end

endmodule

// File: rtl/cbu_cmp.sv
module cbu_cmp
  import cbu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SIZE_N = 4,
  localparam int SZ_W  = $clog2(SIZE_N)
) (
  input  logic [SZ_W-1:0]   cmpSize,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] condVec
);

  logic [DATA_W-1:0] sExtA [SIZE_N];
  logic [DATA_W-1:0] sExtB [SIZE_N];
  logic [DATA_W-1:0] zExtA [SIZE_N];
  logic [DATA_W-1:0] zExtB [SIZE_N];

  // One extension pair per supported width: smallest width at code 0.
  for (genvar k = 0; k < SIZE_N; k++) begin : g_size
    localparam int W = DATA_W >> (SIZE_N - 1 - k);
    if (W == DATA_W) begin : g_full
      assign sExtA[k] = opA;
      assign sExtB[k] = opB;
      assign zExtA[k] = opA;
      assign zExtB[k] = opB;
    end else begin : g_part
      assign sExtA[k] = {{(DATA_W-W){opA[W-1]}}, opA[W-1:0]};
      assign sExtB[k] = {{(DATA_W-W){opB[W-1]}}, opB[W-1:0]};
      assign zExtA[k] = {{(DATA_W-W){1'b0}}, opA[W-1:0]};
      assign zExtB[k] = {{(DATA_W-W){1'b0}}, opB[W-1:0]};
    end
  end

  logic [DATA_W-1:0] selSA, selSB, selZA, selZB;
  logic isEq, sLess, uLess;

  always_comb begin
    selSA = sExtA[cmpSize];
    selSB = sExtB[cmpSize];
    selZA = zExtA[cmpSize];
    selZB = zExtB[cmpSize];
    isEq  = (selZA == selZB);
    sLess = ($signed(selSA) < $signed(selSB));
    uLess = (selZA < selZB);

    condVec         = '0;
    condVec[CV_EQ]  = isEq;
    condVec[CV_NE]  = !isEq;
    condVec[CV_SLT] = sLess;
    condVec[CV_SLE] = sLess | isEq;
    condVec[CV_SGT] = !(sLess | isEq);
    condVec[CV_SGE] = !sLess;
    condVec[CV_ULT] = uLess;
    condVec[CV_ULE] = uLess | isEq;
    condVec[CV_UGT] = !(uLess | isEq);
    condVec[CV_UGE] = !uLess;
  end

endmodule

// File: rtl/cbu_dp.sv
module cbu_dp
  import cbu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_AW = 6,
  parameter int SIZE_N = 4,
  localparam int SZ_W  = $clog2(SIZE_N),
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [SZ_W-1:0]   cmpSize,
  input  logic [DATA_W-1:0] cmpOpA,
  input  logic [DATA_W-1:0] cmpOpB,
  input  logic [REG_AW-1:0] cmpDest,
  input  logic [IDX_W-1:0]  brBitIdx,
  input  logic [DATA_W-1:0] brSrc,
  output logic              wrEn,
  output logic [REG_AW-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              brDone,
  output logic              brTaken
);

  logic [DATA_W-1:0] condVec;
  logic              testVal;

  cbu_cmp #(.DATA_W(DATA_W), .SIZE_N(SIZE_N)) u_cmp (
    .cmpSize (cmpSize),
    .opA     (cmpOpA),
    .opB     (cmpOpB),
    .condVec (condVec)
  );

  // Value under test: one selected bit, or "any bit set" of the register.
  always_comb begin
    if (strobe.brWholeReg) testVal = |brSrc;
    else                   testVal = brSrc[brBitIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn    <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
      brDone  <= 1'b0;
      brTaken <= 1'b0;
    end else begin
      wrEn    <= strobe.cmpLoad;
      if (strobe.cmpLoad) begin
        wrAddr <= cmpDest;
        wrData <= condVec;
      end
      brDone  <= strobe.brLoad;
      brTaken <= strobe.brLoad & (testVal == strobe.brWantSet);
    end
  end

endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_AW = 6,
  parameter int SIZE_N = 4,
  localparam int SZ_W  = $clog2(SIZE_N),
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpValid,
  input  logic [SZ_W-1:0]   cmpSize,
  input  logic [DATA_W-1:0] cmpOpA,
  input  logic [DATA_W-1:0] cmpOpB,
  input  logic [REG_AW-1:0] cmpDest,
  input  logic              brValid,
  input  logic [1:0]        brMode,
  input  logic [IDX_W-1:0]  brBitIdx,
  input  logic [DATA_W-1:0] brSrc,
  output logic              wrEn,
  output logic [REG_AW-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              brDone,
  output logic              brTaken
);

  ctrlStrobe_t strobe;

  cbu_ctrl u_ctrl (
    .cmpValid (cmpValid),
    .brValid  (brValid),
    .brMode   (brMode),
    .strobe   (strobe)
  );

  cbu_dp #(.DATA_W(DATA_W), .REG_AW(REG_AW), .SIZE_N(SIZE_N)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmpSize  (cmpSize),
    .cmpOpA   (cmpOpA),
    .cmpOpB   (cmpOpB),
    .cmpDest  (cmpDest),
    .brBitIdx (brBitIdx),
    .brSrc    (brSrc),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .brDone   (brDone),
    .brTaken  (brTaken)
  );

endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
  parameter int DATA_W = 64,
  parameter int REG_AW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmpValid,
  input logic [REG_AW-1:0] cmpDest,
  input logic              brValid,
  input logic [1:0]        brMode,
  input logic [DATA_W-1:0] brSrc,
  input logic              wrEn,
  input logic [REG_AW-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              brDone,
  input logic              brTaken
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!wrEn && !brDone && !brTaken));

  a_r2_write_follows: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid |=> (wrEn && wrAddr == $past(cmpDest)));

  a_r2_no_spurious_write: assert property (@(posedge clk) disable iff (!rstN)
    !cmpValid |=> !wrEn);

  a_r3_eq_ne_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrData[0] != wrData[1]));

  a_r4_signed_consistent: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrData[3] == (wrData[2] | wrData[0]) && wrData[4] == !wrData[3]
              && wrData[5] == !wrData[2] && !(wrData[0] && wrData[2])));

  a_r5_unsigned_consistent: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrData[7] == (wrData[6] | wrData[0]) && wrData[8] == !wrData[7]
              && wrData[9] == !wrData[6] && !(wrData[0] && wrData[6])));

  a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrData[DATA_W-1:10] == '0));

  a_r9_whole_register: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brMode[1]) |=> (brTaken == (($past(brSrc) != '0) == $past(brMode[0]))));

  a_r10_done_timing: assert property (@(posedge clk) disable iff (!rstN)
    brValid |=> brDone);

  a_r10_taken_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    !brDone |-> !brTaken);

endmodule

bind cmp_branch_unit cbu_checker #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmpValid (cmpValid),
  .cmpDest  (cmpDest),
  .brValid  (brValid),
  .brMode   (brMode),
  .brSrc    (brSrc),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .brDone   (brDone),
  .brTaken  (brTaken)
);

// File: tb/cmp_branch_unit_tb.sv
module cmp_branch_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmpValid = 1'b0;
  logic [1:0]  cmpSize = '0;
  logic [63:0] cmpOpA = '0, cmpOpB = '0;
  logic [5:0]  cmpDest = '0;
  logic        brValid = 1'b0;
  logic [1:0]  brMode = '0;
  logic [5:0]  brBitIdx = '0;
  logic [63:0] brSrc = '0;
  logic        wrEn, brDone, brTaken;
  logic [5:0]  wrAddr;
  logic [63:0] wrData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  cmp_branch_unit u_dut (
    .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .cmpSize(cmpSize),
    .cmpOpA(cmpOpA), .cmpOpB(cmpOpB), .cmpDest(cmpDest), .brValid(brValid),
    .brMode(brMode), .brBitIdx(brBitIdx), .brSrc(brSrc), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .brDone(brDone), .brTaken(brTaken)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  addr;
    logic [63:0] data;
    logic        done;
    logic        taken;
    logic [1:0]  mode;
  } exp_t;

  exp_t  expQ[$];
  string noteQ[$];

  function automatic logic [63:0] refVec(logic [63:0] a, logic [63:0] b, logic [1:0] sz);
    int sh = 64 - (8 << sz);
    logic [63:0] ua = (a << sh) >> sh;
    logic [63:0] ub = (b << sh) >> sh;
    logic signed [63:0] sa = $signed(a << sh) >>> sh;
    logic signed [63:0] sb = $signed(b << sh) >>> sh;
    logic [63:0] v = '0;
    v[0] = (ua == ub); v[1] = (ua != ub);
    v[2] = (sa < sb);  v[3] = (sa <= sb); v[4] = (sa > sb); v[5] = (sa >= sb);
    v[6] = (ua < ub);  v[7] = (ua <= ub); v[8] = (ua > ub); v[9] = (ua >= ub);
    return v;
  endfunction

  function automatic logic refTaken(logic [1:0] m, logic [5:0] idx, logic [63:0] s);
    case (m)
      2'd0: return !s[idx];
      2'd1: return s[idx];
      2'd2: return (s == 0);
      default: return (s != 0);
    endcase
  endfunction

  task automatic check(string req, string note, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s): actual %h expected %h", req, note, act, exp);
    end
  endtask

  task automatic compareOut();
    exp_t e;
    string n;
    if (expQ.size() == 0) return;
    e = expQ.pop_front();
    n = noteQ.pop_front();
    check("R2", n, 64'(wrEn), 64'(e.wr));
    if (e.wr) begin
      check("R2", n, 64'(wrAddr), 64'(e.addr));
      check("R3", n, 64'(wrData[1:0]), 64'(e.data[1:0]));
      check("R4", n, 64'(wrData[5:2]), 64'(e.data[5:2]));
      check("R5", n, 64'(wrData[9:6]), 64'(e.data[9:6]));
      check("R6", n, 64'(wrData[63:10]), 64'(e.data[63:10]));
    end
    check("R10", n, 64'(brDone), 64'(e.done));
    if (e.done) check(e.mode[1] ? "R9" : "R8", n, 64'(brTaken), 64'(e.taken));
    else        check("R10", n, 64'(brTaken), 64'd0);
  endtask

  // Drive one cycle of stimulus; outputs of the previous cycle are checked first.
  task automatic step(string note, logic cv, logic [1:0] sz, logic [63:0] a, logic [63:0] b,
                      logic [5:0] dst, logic bv, logic [1:0] m, logic [5:0] idx, logic [63:0] s);
    exp_t e;
    @(negedge clk);
    compareOut();
    cmpValid = cv; cmpSize = sz; cmpOpA = a; cmpOpB = b; cmpDest = dst;
    brValid = bv; brMode = m; brBitIdx = idx; brSrc = s;
    e.wr = cv; e.addr = dst; e.data = refVec(a, b, sz);
    e.done = bv; e.taken = bv && refTaken(m, idx, s); e.mode = m;
    expQ.push_back(e);
    noteQ.push_back(note);
  endtask

  task automatic idle(string note);
    step(note, 1'b0, 2'd0, 64'd0, 64'd0, 6'd0, 1'b0, 2'd0, 6'd0, 64'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsr = 64'hACE1_2468_1357_BDF9;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "in reset", 64'({wrEn, brDone, brTaken}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "first cycle after reset", 64'({wrEn, brDone, brTaken}), 64'd0);

    // R3/R7: equal after truncation to 8 bits, upper bits ignored
    step("R7 eq after trunc 8", 1, 2'd0, 64'hFFFF_0000_0000_0155, 64'h0000_1234_0000_7755, 6'd5, 0, 0, 0, 0);
    // R4/R5: 8-bit 0xFF (-1) vs 0x01
    step("R4 R5 sign at 8", 1, 2'd0, 64'h0000_0000_0000_01FF, 64'h0000_0000_0000_0001, 6'd63, 0, 0, 0, 0);
    step("R7 16-bit negative", 1, 2'd1, 64'h0000_0000_0001_8000, 64'h0000_0000_0000_7FFF, 6'd33, 0, 0, 0, 0);
    step("R7 32-bit", 1, 2'd2, 64'h1234_5678_8000_0000, 64'h0000_0000_8000_0000, 6'd1, 0, 0, 0, 0);
    step("R4 64-bit neg", 1, 2'd3, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 6'd10, 0, 0, 0, 0);
    step("R7 64 differs high only", 1, 2'd3, 64'h0100_0000_0000_0000, 64'h0, 6'd20, 0, 0, 0, 0);
    idle("R2 idle after compares");
    // R8: bit tests at edges
    step("R8 bit0 set", 0, 0, 0, 0, 0, 1, 2'd1, 6'd0, 64'h1);
    step("R8 bit0 clear", 0, 0, 0, 0, 0, 1, 2'd0, 6'd0, 64'h1);
    step("R8 bit63 set", 0, 0, 0, 0, 0, 1, 2'd1, 6'd63, 64'h8000_0000_0000_0000);
    step("R8 bit31 clear", 0, 0, 0, 0, 0, 1, 2'd0, 6'd31, 64'hFFFF_FFFF_7FFF_FFFF);
    step("R8 bit32 set off", 0, 0, 0, 0, 0, 1, 2'd1, 6'd32, 64'hFFFF_FFFE_FFFF_FFFF);
    // R9: whole-register tests with bit index ignored
    step("R9 zero reg", 0, 0, 0, 0, 0, 1, 2'd2, 6'd17, 64'h0);
    step("R9 top bit nonzero", 0, 0, 0, 0, 0, 1, 2'd3, 6'd0, 64'h8000_0000_0000_0000);
    step("R9 zero on nonzero", 0, 0, 0, 0, 0, 1, 2'd2, 6'd5, 64'h0000_0001_0000_0000);
    step("R9 nonzero on zero", 0, 0, 0, 0, 0, 1, 2'd3, 6'd9, 64'h0);
    idle("R10 no branch");
    // R11: simultaneous compare and branch
    step("R11 both", 1, 2'd2, 64'h5, 64'h5, 6'd7, 1, 2'd1, 6'd2, 64'h4);
    step("R11 both again", 1, 2'd0, 64'h80, 64'h7F, 6'd8, 1, 2'd3, 6'd0, 64'h0);
    // mixed pseudo-random traffic
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b, s;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      a = lfsr;
      b = (i % 5 == 0) ? lfsr ^ 64'hFF00_0000_0000_0000 : {lfsr[31:0], lfsr[63:32]};
      s = (i % 7 == 0) ? 64'h0 : lfsr ^ 64'h5A5A;
      step("R11 random mix", lfsr[3], lfsr[5:4], a, b, lfsr[11:6], lfsr[12], lfsr[14:13], lfsr[20:15], s);
    end
    idle("drain");
    idle("drain");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule